// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block runs a single configuration write on the serial test port of a physical-layer macro. A requester hands it an 8-bit register code and an 8-bit data byte and raises `start`. The block then steps the port's clock, enable and data-in lines through a fixed two-phase pattern. The code is latched by a falling test-clock edge while enable is high. The data byte is latched by the rising test-clock edge that follows once enable has dropped. After the last step it samples the byte the macro returns on its data-out lines and presents it with a one-cycle `done` strobe.

Every step is held for a number of system clocks taken from `hold_cycles`, so slow test ports can be met from a fast system clock. The port also has an active-high clear line, which must be pulsed before any write is accepted. A `clr_req` request runs that pulse. Until one clear has finished after reset, write requests are dropped.

Top module: `phytst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to idle: `tst_clk`=1, `tst_en`=0, `tst_clr`=0, `tst_din`=0, `busy`=0, `done`=0.
- R2: `clr_req` seen in idle holds `tst_clr` high for H cycles and then low for H cycles. During those 2H cycles `busy` is high, `tst_clk` stays 1 and `tst_en` stays 0.
- R3: `start` has no effect until a clear sequence has completed since reset: `busy` stays 0 and no `done` appears.
- R4: An accepted write drives the port in this order. First clock high with enable low and data-in zero. Then data-in carries the code. Then enable rises. Then the clock falls, which latches the code. Then enable falls. Then data-in carries the data byte. Then the clock rises, which latches the data. Enable is high for 2H cycles and the clock is low for 3H cycles.
- R5: Each of the seven steps lasts H system clocks, so `busy` is high for exactly 7H cycles. H is `hold_cycles`, with a value of 0 treated as 1.
- R6: H is captured when a request is accepted. Changing `hold_cycles` during a sequence does not alter that sequence.
- R7: `tst_dout`, as seen in the last cycle of the final step, appears on `rdata` in the single cycle in which `done` pulses. `rdata` then holds until the next `done`.
- R8: `start` and `clr_req` are ignored while `busy` is high. They cause no extra `done` and no `tst_clr` activity.
- R9: Outside a sequence, `tst_din` is 0, `tst_clk` is 1 and `tst_en` is 0.
- R10: If `clr_req` and `start` are both high in the same idle cycle, the clear runs and the write is dropped.
- R11: A `start` presented in the `done` cycle is accepted, so writes can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_cycles | input | HOLD_W | System clocks per step (0 means 1) |
| clr_req | input | 1 | Request a clear pulse on the test port |
| start | input | 1 | Request a write transaction |
| code | input | 8 | Register code for the write |
| wdata | input | 8 | Data byte for the write |
| busy | output | 1 | A clear or write sequence is in progress |
| done | output | 1 | One-cycle strobe when a write finishes |
| rdata | output | 8 | Byte returned by the port, valid with `done` |
| tst_clk | output | 1 | Test-port clock |
| tst_en | output | 1 | Test-port enable (high during the code phase) |
| tst_clr | output | 1 | Test-port clear, active high |
| tst_din | output | 8 | Test-port data-in |
| tst_dout | input | 8 | Test-port data-out |

## Verification
Two functions can collide in one cycle: finishing a write, which raises `done` and returns to idle, and accepting the next request. The bench provokes this by raising `start` in the very cycle it sees `done`. It then judges that `busy` is high one cycle later and that the second write returns its own byte with the full 7H length. A second collision is `clr_req` and `start` in the same idle cycle. This is judged by counting `tst_clr` high cycles and confirming that no `done` follows.

// File: rtl/phytst_pkg.sv
// Package: phytst_pkg
// Shared step encoding and pin-level decode for the PHY test-port sequencer.
// Assumes an 8-bit test data path on the port.
package phytst_pkg;

    parameter int TST_DW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_SETUP,
        ST_CODE,
        ST_EN,
        ST_CLKLO,
        ST_ENLO,
        ST_DATA,
        ST_CLKHI
    } step_e;

    typedef struct packed {
        logic              clk;
        logic              en;
        logic              clr;
        logic [TST_DW-1:0] din;
    } pins_t;

    // Successor of a timed step once its hold interval has elapsed.
    function automatic step_e next_step(input step_e s);
        case (s)
            ST_CLR_HI: next_step = ST_CLR_LO;
            ST_CLR_LO: next_step = ST_IDLE;
            ST_SETUP:  next_step = ST_CODE;
            ST_CODE:   next_step = ST_EN;
            ST_EN:     next_step = ST_CLKLO;
            ST_CLKLO:  next_step = ST_ENLO;
            ST_ENLO:   next_step = ST_DATA;
            ST_DATA:   next_step = ST_CLKHI;
            default:   next_step = ST_IDLE;
        endcase
    endfunction

    // Port levels that belong to each step.
    function automatic pins_t pins_for(input step_e s,
                                       input logic [TST_DW-1:0] code,
                                       input logic [TST_DW-1:0] data);
        pins_t p;
        p.clk = 1'b1;
        p.en  = 1'b0;
        p.clr = 1'b0;
        p.din = '0;
        case (s)
            ST_CLR_HI: p.clr = 1'b1;
            ST_CODE:   p.din = code;
            ST_EN:     begin p.en = 1'b1; p.din = code; end
            ST_CLKLO:  begin p.clk = 1'b0; p.en = 1'b1; p.din = code; end
            ST_ENLO:   begin p.clk = 1'b0; p.din = code; end
            ST_DATA:   begin p.clk = 1'b0; p.din = data; end
            ST_CLKHI:  p.din = data;
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/phytst_hold_timer.sv
// Module: phytst_hold_timer
// Counts system clocks inside one step and flags the last cycle of it.
// Assumes: the span is latched on 'load' (a request acceptance); a zero
// span request is widened to one cycle.
module phytst_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              active,
    output logic              step_end
);

    localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

    logic [HOLD_W-1:0] span_q;
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] span_eff;

    // Widen a zero request to the one-cycle minimum.
    always_comb begin
        span_eff = (hold_cycles == '0) ? ONE : hold_cycles;
    end

    // Last cycle of the current step.
    always_comb begin
        step_end = active && (cnt_q == (span_q - ONE));
    end

    // Latch the span at acceptance and count cycles within the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= ONE;
            cnt_q  <= '0;
        end else if (load) begin
            span_q <= span_eff;
            cnt_q  <= '0;
        end else if (step_end) begin
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q  <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/phytst_step_fsm.sv
// Module: phytst_step_fsm
// Accepts clear and write requests and walks the step sequence.
// Assumes: requests are only looked at in idle; clear wins over a write
// in the same cycle; writes wait for one completed clear after reset.
module phytst_step_fsm
    import phytst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clr_req,
    input  logic [TST_DW-1:0] code,
    input  logic [TST_DW-1:0] wdata,
    input  logic              step_end,
    output logic              load,
    output step_e             state_d,
    output logic [TST_DW-1:0] code_q,
    output logic [TST_DW-1:0] data_q,
    output logic              capture,
    output logic              busy
);

    step_e state_q;
    logic  cleared_q;
    logic  take_wr;

    // Next-step selection and request acceptance.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        take_wr = 1'b0;
        if (state_q == ST_IDLE) begin
            if (clr_req) begin
                state_d = ST_CLR_HI;
                load    = 1'b1;
            end else if (start && cleared_q) begin
                state_d = ST_SETUP;
                load    = 1'b1;
                take_wr = 1'b1;
            end
        end else if (step_end) begin
            state_d = next_step(state_q);
        end
    end

    // Final step completing means the returned byte is to be sampled.
    always_comb begin
        capture = step_end && (state_q == ST_CLKHI);
        busy    = (state_q != ST_IDLE);
    end

    // Step register and clear-completed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cleared_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (step_end && state_q == ST_CLR_LO) begin
                cleared_q <= 1'b1;
            end
        end
    end

    // Hold the write operands for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            data_q <= '0;
        end else if (take_wr) begin
            code_q <= code;
            data_q <= wdata;
        end
    end

endmodule

// File: rtl/phytst_pin_drv.sv
// Module: phytst_pin_drv
// Registers the test-port levels for the coming step and captures the
// returned byte. Assumes operands are stable from the step after acceptance.
module phytst_pin_drv
    import phytst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             state_d,
    input  logic [TST_DW-1:0] code_q,
    input  logic [TST_DW-1:0] data_q,
    input  logic              capture,
    input  logic [TST_DW-1:0] tst_dout,
    output logic              tst_clk,
    output logic              tst_en,
    output logic              tst_clr,
    output logic [TST_DW-1:0] tst_din,
    output logic              done,
    output logic [TST_DW-1:0] rdata
);

    pins_t pins_q;

    // Glitch-free port levels, updated on the same edge as the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= pins_for(ST_IDLE, '0, '0);
        end else begin
            pins_q <= pins_for(state_d, code_q, data_q);
        end
    end

    // Capture the returned byte and raise the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= capture;
            if (capture) begin
                rdata <= tst_dout;
            end
        end
    end

    assign tst_clk = pins_q.clk;
    assign tst_en  = pins_q.en;
    assign tst_clr = pins_q.clr;
    assign tst_din = pins_q.din;

endmodule

// File: rtl/phytst_seq.sv
// Module: phytst_seq
// Top of the PHY test-port write sequencer: request FSM, step hold timer
// and registered pin driver. Assumes a synchronous active-low reset and
// that tst_dout is settled by the last cycle of the final step.
module phytst_seq
    import phytst_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              clr_req,
    input  logic              start,
    input  logic [TST_DW-1:0] code,
    input  logic [TST_DW-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [TST_DW-1:0] rdata,
    output logic              tst_clk,
    output logic              tst_en,
    output logic              tst_clr,
    output logic [TST_DW-1:0] tst_din,
    input  logic [TST_DW-1:0] tst_dout
);

    logic              load;
    logic              step_end;
    logic              capture;
    step_e             state_d;
    logic [TST_DW-1:0] code_q;
    logic [TST_DW-1:0] data_q;

    phytst_step_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .clr_req  (clr_req),
        .code     (code),
        .wdata    (wdata),
        .step_end (step_end),
        .load     (load),
        .state_d  (state_d),
        .code_q   (code_q),
        .data_q   (data_q),
        .capture  (capture),
        .busy     (busy)
    );

    phytst_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .hold_cycles (hold_cycles),
        .active      (busy),
        .step_end    (step_end)
    );

    phytst_pin_drv u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (state_d),
        .code_q   (code_q),
        .data_q   (data_q),
        .capture  (capture),
        .tst_dout (tst_dout),
        .tst_clk  (tst_clk),
        .tst_en   (tst_en),
        .tst_clr  (tst_clr),
        .tst_din  (tst_din),
        .done     (done),
        .rdata    (rdata)
    );

endmodule

// File: rtl/phytst_seq_chk.sv
// Module: phytst_seq_chk
// Protocol checker for phytst_seq, attached by bind. Relates the port
// edges to each other and to the handshake outputs.
module phytst_seq_chk
    import phytst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [TST_DW-1:0] rdata,
    input logic              tst_clk,
    input logic              tst_en,
    input logic              tst_clr,
    input logic [TST_DW-1:0] tst_din
);

    AST_EN_RISES_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tst_en) |-> tst_clk); // R4
    AST_CLK_FALLS_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_clk) |-> tst_en); // R4
    AST_EN_FALLS_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_en) |-> !tst_clk); // R4
    AST_CLK_RISES_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tst_clk) |-> !tst_en); // R4
    AST_DIN_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tst_clk) |-> $stable(tst_din)); // R4
    AST_DIN_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tst_clk) |-> $stable(tst_din)); // R4
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tst_clk && !tst_en && !tst_clr && tst_din == '0)); // R9
    AST_CLEAR_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        tst_clr |-> (tst_clk && !tst_en && busy)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata)); // R7

endmodule

bind phytst_seq phytst_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .tst_clk (tst_clk),
    .tst_en  (tst_en),
    .tst_clr (tst_clr),
    .tst_din (tst_din)
);

// File: tb/tb_phytst_seq.sv
module tb_phytst_seq;

    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] hold_cycles = 8'd1;
    logic          clr_req = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    code = 8'h00;
    logic [7:0]    wdata = 8'h00;
    logic          busy;
    logic          done;
    logic [7:0]    rdata;
    logic          tst_clk;
    logic          tst_en;
    logic          tst_clr;
    logic [7:0]    tst_din;
    logic [7:0]    tst_dout;

    phytst_seq #(.HOLD_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .hold_cycles(hold_cycles),
        .clr_req(clr_req), .start(start), .code(code), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_clr(tst_clr),
        .tst_din(tst_din), .tst_dout(tst_dout)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit closed = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Port model: code latched on falling clock with enable high,
    // returned byte formed on rising clock with enable low.
    logic [7:0] m_code = 8'h00;
    logic [7:0] m_dout = 8'h00;
    always @(negedge tst_clk) if (tst_en === 1'b1) m_code <= tst_din;
    always @(posedge tst_clk) if (tst_en === 1'b0) m_dout <= m_code ^ tst_din ^ 8'h5A;
    assign tst_dout = m_dout;

    // Scoreboard queues filled by the driver.
    logic [7:0] exp_q[$];
    int         hold_q[$];
    int         done_total = 0;
    int         n_busy = 0, n_en = 0, n_lo = 0, n_clr = 0;
    logic       prev_busy = 1'b0;

    // Monitor: measures each sequence and compares at completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                n_busy = 0; n_en = 0; n_lo = 0; n_clr = 0;
            end
            if (busy) n_busy++;
            if (tst_en) n_en++;
            if (!tst_clk) n_lo++;
            if (tst_clr) n_clr++;
            if (done) begin
                done_total++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected done", 1, 0);
                end else begin
                    logic [7:0] e;
                    int h;
                    e = exp_q.pop_front();
                    h = hold_q.pop_front();
                    chk(rdata == e, "R7 returned byte", rdata, e);
                    chk(n_busy == 7*h, "R5 busy length", n_busy, 7*h);
                    chk(n_en == 2*h, "R4 enable high cycles", n_en, 2*h);
                    chk(n_lo == 3*h, "R4 clock low cycles", n_lo, 3*h);
                    chk(n_clr == 0, "R8 clear quiet in write", n_clr, 0);
                    chk(tst_clk && !tst_en && tst_din == 8'h00, "R9 idle levels", tst_din, 0);
                end
            end
            prev_busy = busy;
        end
    end

    task automatic start_txn(input logic [7:0] c, input logic [7:0] d, input int h);
        @(negedge clk);
        hold_cycles = h[HW-1:0];
        code  = c;
        wdata = d;
        start = 1'b1;
        exp_q.push_back(c ^ d ^ 8'h5A);
        hold_q.push_back((h == 0) ? 1 : h);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 write accepted", busy, 1);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || exp_q.size() != 0);
        @(negedge clk);
    endtask

    task automatic run_clear(input int h, input bit with_start, input string tag);
        int n_hi;
        int n_b;
        @(negedge clk);
        hold_cycles = h[HW-1:0];
        clr_req = 1'b1;
        start = with_start;
        @(negedge clk);
        clr_req = 1'b0;
        start = 1'b0;
        n_hi = 0;
        n_b = 0;
        while (busy) begin
            n_b++;
            if (tst_clr) n_hi++;
            @(negedge clk);
        end
        chk(n_hi == h, {tag, " clear high cycles"}, n_hi, h);
        chk(n_b == 2*h, {tag, " clear busy cycles"}, n_b, 2*h);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1: reset levels
        chk(tst_clk && !tst_en && !tst_clr && tst_din == 8'h00, "R1 port reset levels", tst_din, 0);
        chk(!busy && !done, "R1 handshake reset", busy, 0);
        rst_n = 1'b1;

        // R3: write before any clear is dropped
        @(negedge clk);
        code = 8'h3E; wdata = 8'h81; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        chk(busy == 1'b0, "R3 start before clear", busy, 0);
        chk(done_total == 0, "R3 no done before clear", done_total, 0);

        // R2: clear pulse with H=2
        run_clear(2, 1'b0, "R2");

        // R4 R5: writes with several hold values
        start_txn(8'h44, 8'h22, 1); wait_idle();
        start_txn(8'hA5, 8'h3C, 0); wait_idle();   // R5 zero widened to one
        start_txn(8'h17, 8'hE8, 3); wait_idle();
        start_txn(8'hFF, 8'h00, 5); wait_idle();

        // R6: hold changed mid-sequence
        start_txn(8'h5C, 8'h91, 2);
        hold_cycles = 8'd6;
        wait_idle();

        // R8: requests during a write are ignored
        d0 = done_total;
        start_txn(8'h12, 8'h34, 2);
        @(negedge clk);
        start = 1'b1; clr_req = 1'b1; code = 8'h99;
        @(negedge clk);
        start = 1'b0; clr_req = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(done_total == d0 + 1, "R8 single completion", done_total, d0 + 1);
        chk(busy == 1'b0, "R8 no follow-on sequence", busy, 0);
        chk(rdata == (8'h12 ^ 8'h34 ^ 8'h5A), "R7 rdata held", rdata, 8'h12 ^ 8'h34 ^ 8'h5A);

        // R10: clear and write requested together
        d0 = done_total;
        run_clear(3, 1'b1, "R10");
        repeat (30) @(negedge clk);
        chk(done_total == d0, "R10 write dropped", done_total, d0);

        // R11: new write presented in the done cycle
        start_txn(8'h6B, 8'h0F, 1);
        do @(negedge clk); while (!done);
        code = 8'hC3; wdata = 8'h7E; hold_cycles = 8'd1; start = 1'b1;
        exp_q.push_back(8'hC3 ^ 8'h7E ^ 8'h5A);
        hold_q.push_back(1);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 back-to-back accept", busy, 1);
        wait_idle();

        if (!closed) begin
            closed = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!closed) begin
            closed = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule